// File: doc/BRIEF.md
# Multiplexed Key Scan Window Controller

This block reads four key lines that share their pins with an LCD segment driver. Software starts a scan by writing a key-source value into a source register. The block then opens a fixed-length scan window. While the window is open, it drives the source value out, enables the pin pull-downs and lets the key lines through to an input latch. When the window closes, the pins go back to segment duty, the latch holds its value, and a ready flag is raised.

Software polls the ready flag through a small register port. It clears the flag by reading it, or by starting another scan. After that it reads the captured key bits from a data register. The window length is given in microseconds together with the clock frequency, and the cycle count is derived from them. A build option selects what the latch keeps. Track mode keeps the pin state from the final window cycle. Accumulate mode keeps every key seen at any point in the window.

Top module: `key_scan_ctrl`

## Requirements
- R1: While reset is asserted, pulldown_en is 0, seg_phase is 1, key_src_out is 0, and a read of the ready register (address 0x16, bit 0) or of the key data register returns 0.
- R2: A write to the source register opens the window. It opens in the cycle after the write and stays open for exactly WIN_CYCLES = CLK_HZ/1000*WINDOW_US/1000 cycles. In that interval pulldown_en is 1, seg_phase is 0 and key_src_out equals the written value. Outside it pulldown_en is 0, seg_phase is 1 and key_src_out is 0.
- R3: The ready flag reads 0 while the window is open. It reads 1 in bit 0 at address 0x16 from the first cycle after a window has run to its end.
- R4: A read at address 0x16 clears the ready flag from the next cycle onward, unless a window finishes in that same cycle.
- R5: A write to the source register clears the ready flag. If a window is already open, the write restarts its full length.
- R6: When a window finishes in the same cycle as a ready-flag read, the flag ends up 1.
- R7: In track mode, the key data register returns key_in as sampled in the last cycle of the window, in bits 3:0.
- R8: In accumulate mode, the key data register returns the bitwise OR of key_in over every cycle of the window. The value is cleared when a window starts.
- R9: Changes on key_in while the window is closed do not alter the key data register.
- R10: Writes and reads at addresses other than the source and ready registers leave the ready flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data for cpu_addr, combinational |
| key_in | input | KEY_W | Key return lines from the shared pins |
| key_src_out | output | DATA_W | Key-source value driven during the window |
| pulldown_en | output | 1 | Pull-down enable for the key pins |
| seg_phase | output | 1 | High when the pins belong to segment output |

## Verification
The bench builds the block with CLK_HZ set to 50 kHz and the window at 220 µs, which gives an 11-cycle window. With a window that short, the bench can cover several full windows, a restart part-way through a window, and a ready-flag read placed exactly on the finishing cycle, all in a few hundred cycles. It builds two instances on the same inputs, one in track mode and one in accumulate mode. Because both see one key pattern, the same stimulus shows the last-sample result and the OR-of-window result side by side.

// File: rtl/ksc_pkg.sv
package ksc_pkg;

   typedef enum logic [0:0] {
      LATCH_TRACK = 1'b0,
      LATCH_ACCUM = 1'b1
   } latch_mode_e;

   // cycles in a window of win_us microseconds at clk_hz
   function automatic int unsigned win_cycles(input int unsigned clk_hz,
                                              input int unsigned win_us);
      return ((clk_hz / 1000) * win_us) / 1000;
   endfunction

endpackage

// File: rtl/ksc_window_timer.sv
module ksc_window_timer #(
   parameter int unsigned WIN_CYCLES = 22000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic done
);
   localparam int unsigned CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             act_q;

   // a restart in the finishing cycle wins: the window is not complete
   assign done   = act_q && (cnt_q == LAST) && !start;
   assign active = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (done) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (act_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ksc_judge_flag.sv
module ksc_judge_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr_wr,
   input  logic clr_rd,
   output logic q
);
   // priority: new source write, then window completion, then read-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (clr_wr)  q <= 1'b0;
      else if (set)     q <= 1'b1;
      else if (clr_rd)  q <= 1'b0;
   end
endmodule

// File: rtl/ksc_key_latch.sv
module ksc_key_latch
   import ksc_pkg::*;
#(
   parameter int unsigned KEY_W      = 4,
   parameter latch_mode_e LATCH_MODE = LATCH_TRACK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open,
   input  logic             restart,
   input  logic [KEY_W-1:0] key_in,
   output logic [KEY_W-1:0] key_q
);
   logic [KEY_W-1:0] hold_q;

   generate
      if (LATCH_MODE == LATCH_ACCUM) begin : g_accum
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hold_q <= '0;
            else if (restart)  hold_q <= '0;
            else if (open)     hold_q <= hold_q | key_in;
         end
      end else begin : g_track
         logic unused_restart;
         assign unused_restart = restart;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hold_q <= '0;
            else if (open)  hold_q <= key_in;
         end
      end
   endgenerate

   assign key_q = hold_q;

endmodule

// File: rtl/ksc_regif.sv
module ksc_regif #(
   parameter int unsigned     ADDR_W     = 7,
   parameter int unsigned     DATA_W     = 4,
   parameter int unsigned     KEY_W      = 4,
   parameter logic [ADDR_W-1:0] SRC_ADDR   = 7'h10,
   parameter logic [ADDR_W-1:0] JUDGE_ADDR = 7'h16,
   parameter logic [ADDR_W-1:0] KEY_ADDR   = 7'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              judge,
   input  logic [KEY_W-1:0]  key_data,
   output logic              wr_src,
   output logic              rd_judge,
   output logic [DATA_W-1:0] src_q
);
   logic [DATA_W-1:0] key_ext;
   logic [DATA_W-1:0] judge_ext;

   assign wr_src   = cpu_wr && (cpu_addr == SRC_ADDR);
   assign rd_judge = cpu_rd && (cpu_addr == JUDGE_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      src_q <= '0;
      else if (wr_src) src_q <= cpu_wdata;
   end

   always_comb begin
      key_ext               = '0;
      key_ext[KEY_W-1:0]    = key_data;
      judge_ext             = '0;
      judge_ext[0]          = judge;
   end

   always_comb begin
      unique case (cpu_addr)
         SRC_ADDR:   cpu_rdata = src_q;
         JUDGE_ADDR: cpu_rdata = judge_ext;
         KEY_ADDR:   cpu_rdata = key_ext;
         default:    cpu_rdata = '0;
      endcase
   end

endmodule

// File: rtl/key_scan_ctrl.sv
module key_scan_ctrl
   import ksc_pkg::*;
#(
   parameter int unsigned       CLK_HZ     = 100_000_000,
   parameter int unsigned       WINDOW_US  = 220,
   parameter int unsigned       KEY_W      = 4,
   parameter int unsigned       DATA_W     = 4,
   parameter int unsigned       ADDR_W     = 7,
   parameter logic [ADDR_W-1:0] SRC_ADDR   = 7'h10,
   parameter logic [ADDR_W-1:0] JUDGE_ADDR = 7'h16,
   parameter logic [ADDR_W-1:0] KEY_ADDR   = 7'h70,
   parameter latch_mode_e       LATCH_MODE = LATCH_TRACK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [KEY_W-1:0]  key_in,
   output logic [DATA_W-1:0] key_src_out,
   output logic              pulldown_en,
   output logic              seg_phase
);
   localparam int unsigned WIN_CYCLES = win_cycles(CLK_HZ, WINDOW_US);

   initial begin : p_param_chk
      assert (KEY_W == 4) else $fatal(1, "key_scan_ctrl: KEY_W must be 4");
      assert (KEY_W <= DATA_W) else $fatal(1, "key_scan_ctrl: DATA_W too narrow");
      assert (WIN_CYCLES >= 2) else $fatal(1, "key_scan_ctrl: window under 2 cycles");
      assert (SRC_ADDR != JUDGE_ADDR && SRC_ADDR != KEY_ADDR && JUDGE_ADDR != KEY_ADDR)
         else $fatal(1, "key_scan_ctrl: register addresses collide");
   end

   logic              wr_src;
   logic              rd_judge;
   logic [DATA_W-1:0] src_q;
   logic              win_active;
   logic              win_done;
   logic              judge_q;
   logic [KEY_W-1:0]  latch_q;

   ksc_regif #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .KEY_W      (KEY_W),
      .SRC_ADDR   (SRC_ADDR),
      .JUDGE_ADDR (JUDGE_ADDR),
      .KEY_ADDR   (KEY_ADDR)
   ) regif_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_rd    (cpu_rd),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .judge     (judge_q),
      .key_data  (latch_q),
      .wr_src    (wr_src),
      .rd_judge  (rd_judge),
      .src_q     (src_q)
   );

   ksc_window_timer #(
      .WIN_CYCLES (WIN_CYCLES)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (wr_src),
      .active (win_active),
      .done   (win_done)
   );

   ksc_judge_flag flag_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (win_done),
      .clr_wr (wr_src),
      .clr_rd (rd_judge),
      .q      (judge_q)
   );

   ksc_key_latch #(
      .KEY_W      (KEY_W),
      .LATCH_MODE (LATCH_MODE)
   ) latch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .open    (win_active),
      .restart (wr_src),
      .key_in  (key_in),
      .key_q   (latch_q)
   );

   assign pulldown_en = win_active;
   assign seg_phase   = !win_active;
   assign key_src_out = win_active ? src_q : '0;

endmodule

// File: rtl/ksc_checker.sv
module ksc_checker #(
   parameter int unsigned       ADDR_W     = 7,
   parameter int unsigned       KEY_W      = 4,
   parameter logic [ADDR_W-1:0] SRC_ADDR   = 7'h10,
   parameter logic [ADDR_W-1:0] JUDGE_ADDR = 7'h16,
   parameter int unsigned       WIN_CYCLES = 22000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              pulldown_en,
   input logic              judge_q,
   input logic [KEY_W-1:0]  latch_q
);
   logic        src_wr;
   logic        jdg_rd;
   int unsigned run_len;

   assign src_wr = cpu_wr && (cpu_addr == SRC_ADDR);
   assign jdg_rd = cpu_rd && (cpu_addr == JUDGE_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_len <= 0;
      else if (src_wr)      run_len <= 0;
      else if (pulldown_en) run_len <= run_len + 1;
      else                  run_len <= 0;
   end

   // R2
   window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulldown_en |-> run_len < WIN_CYCLES);

   // R5
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_wr |=> pulldown_en && !judge_q);

   // R3
   flag_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(judge_q) |-> $past(pulldown_en));

   // R4
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (jdg_rd && !pulldown_en && !src_wr) |=> !judge_q);

   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulldown_en && !src_wr) |=> $stable(latch_q));

   // R10
   other_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_wr && !jdg_rd && !pulldown_en) |=> $stable(judge_q));

endmodule

bind key_scan_ctrl ksc_checker #(
   .ADDR_W     (ADDR_W),
   .KEY_W      (KEY_W),
   .SRC_ADDR   (SRC_ADDR),
   .JUDGE_ADDR (JUDGE_ADDR),
   .WIN_CYCLES (WIN_CYCLES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_wr      (cpu_wr),
   .cpu_rd      (cpu_rd),
   .cpu_addr    (cpu_addr),
   .pulldown_en (pulldown_en),
   .judge_q     (judge_q),
   .latch_q     (latch_q)
);

// File: tb/key_scan_ctrl_tb_top.sv
module key_scan_ctrl_tb_top;
   import ksc_pkg::*;

   localparam int unsigned CLK_HZ = 50_000;
   localparam int unsigned WUS    = 220;
   localparam int          WIN    = 11;
   localparam logic [6:0]  A_SRC  = 7'h10;
   localparam logic [6:0]  A_JDG  = 7'h16;
   localparam logic [6:0]  A_KEY  = 7'h70;
   localparam logic [6:0]  A_OTH  = 7'h33;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [6:0] addr = '0;
   logic [3:0] wdata = '0;
   logic [3:0] key = '0;

   logic [3:0] rdata_t, src_t, rdata_a, src_a;
   logic       pd_t, seg_t, pd_a, seg_a;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   // model state
   int m_active = 0, m_cnt = 0, m_flag = 0, m_lt = 0, m_la = 0, m_src = 0;

   always #5 clk = ~clk;

   key_scan_ctrl #(.CLK_HZ(CLK_HZ), .WINDOW_US(WUS), .LATCH_MODE(LATCH_TRACK)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_wr(wr), .cpu_rd(rd), .cpu_addr(addr),
      .cpu_wdata(wdata), .cpu_rdata(rdata_t), .key_in(key),
      .key_src_out(src_t), .pulldown_en(pd_t), .seg_phase(seg_t));

   key_scan_ctrl #(.CLK_HZ(CLK_HZ), .WINDOW_US(WUS), .LATCH_MODE(LATCH_ACCUM)) dut_acc_i (
      .clk(clk), .rst_n(rst_n), .cpu_wr(wr), .cpu_rd(rd), .cpu_addr(addr),
      .cpu_wdata(wdata), .cpu_rdata(rdata_a), .key_in(key),
      .key_src_out(src_a), .pulldown_en(pd_a), .seg_phase(seg_a));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_rdata(input logic [6:0] a, input int lat);
      case (a)
         A_SRC:   return m_src;
         A_JDG:   return m_flag;
         A_KEY:   return lat;
         default: return 0;
      endcase
   endfunction

   // behavioural reference, evaluated on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_cnt = 0; m_flag = 0; m_lt = 0; m_la = 0; m_src = 0;
      end else begin
         bit w_src, r_jdg, fin;
         w_src = wr && addr == A_SRC;
         r_jdg = rd && addr == A_JDG;
         fin   = m_active != 0 && m_cnt == WIN - 1;
         if (m_active != 0) begin
            m_lt = int'(key);
            m_la = m_la | int'(key);
         end
         if (w_src) begin
            m_src = int'(wdata); m_active = 1; m_cnt = 0; m_flag = 0; m_la = 0;
         end else begin
            if (fin) begin
               m_active = 0; m_cnt = 0; m_flag = 1;
            end else if (m_active != 0) begin
               m_cnt = m_cnt + 1;
            end
            if (!fin && r_jdg) m_flag = 0;
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(pd_t == (m_active != 0), "R2 pulldown_en", int'(pd_t), m_active);
         chk(seg_t == (m_active == 0), "R2 seg_phase", int'(seg_t), int'(m_active == 0));
         chk(int'(src_t) == (m_active != 0 ? m_src : 0), "R2 key_src_out",
             int'(src_t), m_active != 0 ? m_src : 0);
         chk(int'(rdata_t) == exp_rdata(addr, m_lt), "R3/R7 rdata track",
             int'(rdata_t), exp_rdata(addr, m_lt));
         chk(int'(rdata_a) == exp_rdata(addr, m_la), "R8 rdata accum",
             int'(rdata_a), exp_rdata(addr, m_la));
         chk(pd_a == pd_t, "R2 pulldown_en accum", int'(pd_a), int'(pd_t));
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic bus(input bit w, input bit r, input logic [6:0] a, input logic [3:0] d);
      wr = w; rd = r; addr = a; wdata = d;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(10 * 200000);
      tests++;
      fails++;
      $display("FAIL watchdog expired (R1..R10 run incomplete) actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) cyc();
      // R1 reset state
      bus(0, 0, A_JDG, 0); #1;
      chk(pd_t == 0, "R1 pulldown_en", int'(pd_t), 0);
      chk(seg_t == 1, "R1 seg_phase", int'(seg_t), 1);
      chk(src_t == 0, "R1 key_src_out", int'(src_t), 0);
      chk(rdata_t == 0, "R1 ready flag", int'(rdata_t), 0);
      addr = A_KEY; #1;
      chk(rdata_t == 0, "R1 key data", int'(rdata_t), 0);
      rst_n = 1'b1;
      cyc();

      // first window, key pattern 1 at step 2, 8 at last step
      bus(1, 0, A_SRC, 4'h6); cyc(); bus(0, 0, A_JDG, 0);
      chk(pd_t == 1, "R2 window open", int'(pd_t), 1);
      chk(src_t == 4'h6, "R2 source value", int'(src_t), 6);
      for (int i = 0; i < WIN; i++) begin
         key = (i == WIN - 1) ? 4'h8 : (i == 2) ? 4'h1 : 4'h0;
         if (i == WIN - 1) chk(rdata_t[0] == 0, "R3 flag low in window", int'(rdata_t), 0);
         cyc();
      end
      chk(pd_t == 0, "R2 window closed", int'(pd_t), 0);
      chk(rdata_t[0] == 1, "R3 flag set", int'(rdata_t), 1);
      addr = A_KEY; #1;
      chk(rdata_t == 4'h8, "R7 last sample", int'(rdata_t), 8);
      chk(rdata_a == 4'h9, "R8 OR of window", int'(rdata_a), 9);

      // R9 key activity outside window
      key = 4'hF; repeat (3) cyc();
      chk(rdata_t == 4'h8, "R9 track latch held", int'(rdata_t), 8);
      chk(rdata_a == 4'h9, "R9 accum latch held", int'(rdata_a), 9);

      // R10 other addresses
      bus(1, 0, A_OTH, 4'h3); cyc(); bus(0, 1, A_OTH, 0); cyc(); bus(0, 0, A_JDG, 0); #1;
      chk(rdata_t[0] == 1, "R10 flag kept", int'(rdata_t), 1);

      // R4 read clears
      bus(0, 1, A_JDG, 0); cyc(); bus(0, 0, A_JDG, 0); #1;
      chk(rdata_t[0] == 0, "R4 flag cleared by read", int'(rdata_t), 0);

      // R5 restart in progress
      key = 4'h0;
      bus(1, 0, A_SRC, 4'h3); cyc(); bus(0, 0, A_JDG, 0);
      repeat (4) cyc();
      bus(1, 0, A_SRC, 4'h5); cyc(); bus(0, 0, A_JDG, 0);
      repeat (WIN - 1) cyc();
      chk(pd_t == 1, "R5 window restarted", int'(pd_t), 1);
      chk(src_t == 4'h5, "R5 new source value", int'(src_t), 5);
      cyc();
      chk(pd_t == 0, "R5 window ends after restart", int'(pd_t), 0);
      chk(rdata_t[0] == 1, "R5 flag after restarted window", int'(rdata_t), 1);
      bus(1, 0, A_SRC, 4'h2); cyc(); bus(0, 0, A_JDG, 0); #1;
      chk(rdata_t[0] == 0, "R5 flag cleared by write", int'(rdata_t), 0);
      chk(pd_t == 1, "R5 new window open", int'(pd_t), 1);

      // R6 read in the finishing cycle
      repeat (WIN - 1) cyc();
      bus(0, 1, A_JDG, 0); cyc(); bus(0, 0, A_JDG, 0); #1;
      chk(rdata_t[0] == 1, "R6 set wins over read", int'(rdata_t), 1);

      // R8 accumulate cleared at window start, R7 tracks zero
      key = 4'h0;
      bus(1, 0, A_SRC, 4'h1); cyc(); bus(0, 0, A_KEY, 0);
      repeat (WIN) cyc();
      chk(rdata_a == 0, "R8 cleared at start", int'(rdata_a), 0);
      chk(rdata_t == 0, "R7 zero sample", int'(rdata_t), 0);

      repeat (2) cyc();
      summary();
   end

endmodule